// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a watchdog timer that takes its time from a free-running timebase counter. The counter advances on every clock and is visible to software as a read-only register. The watchdog is armed only when two enable bits, held in two separate control registers, are both set. This makes an accidental enable or disable by a single stray write unlikely.

Each time the low `INTERVAL_N` bits of the timebase wrap, an expiry event occurs. While the watchdog is armed, the first expiry sets a stage flag and sends a one-cycle interrupt. A second expiry that arrives while the stage flag is still set drives the system reset output for a fixed number of cycles. It also sets a sticky reset-cause flag and disarms the watchdog. Software keeps the system alive by writing 1 to the stage flag before the next expiry. The reset-cause flag is cleared only by power-on reset or by a write of 1, so software can read it after the system restarts.

Register access uses a single-cycle port. A write takes effect at the clock edge on which `reg_we` is high. Read data is a combinational function of `reg_addr`. A build parameter can lock the enables once the watchdog has been armed.

Top module: `twostage_wdt`

## Requirements
- R1: After power-on reset, control registers 0 (byte offset 0x0) and 1 (offset 0x4) read 0, and `irq` and `sys_rst` are low.
- R2: Offset 0x8 reads the timebase. The timebase is zero-extended and increases by exactly one per clock. Writes to offset 0x8 do not disturb it.
- R3: Control register 0 holds enable A at bit 1, the stage flag at bit 2 and the reset-cause flag at bit 3; its other bits read 0. Control register 1 holds enable B at bit 0; its other bits read 0. Any offset other than 0x0, 0x4 and 0x8 reads 0, and writes to such offsets change nothing.
- R4: The watchdog is armed only while enable A and enable B are both 1. While it is not armed, expiries do not change the stage flag or the reset-cause flag and raise neither `irq` nor `sys_rst`.
- R5: An expiry is processed at the clock edge that ends a cycle in which the timebase's low `INTERVAL_N` bits are all ones. When the watchdog is armed and the stage flag is 0, this edge sets the stage flag, and `irq` is high for exactly the one following cycle.
- R6: Writing 1 to bit 2 of control register 0 clears the stage flag (the keepalive). Writing 0 to bit 2 leaves it unchanged. Writing 1 to bit 3 clears the reset-cause flag.
- R7: An armed expiry that finds the stage flag set makes `sys_rst` high for exactly `RST_LEN` cycles, starting in the cycle after that edge. The same edge sets the reset-cause flag, clears the stage flag and both enables, and raises no `irq`.
- R8: The reset-cause flag keeps its value through and after a `sys_rst` pulse. Writes of 0 to bit 3 do not clear it.
- R9: When an expiry and a write of 1 to the stage flag fall on the same edge, the expiry wins. If the stage flag was 0, it ends at 1 and `irq` pulses. If it was 1, the reset fires.
- R10: With `ENABLE_ONCE`=1, once the watchdog is armed, writes cannot clear either enable bit until a watchdog reset or a power-on reset. With `ENABLE_ONCE`=0, writes clear them freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside the block |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq | output | 1 | One-cycle pulse on a first armed expiry |
| sys_rst | output | 1 | System reset request, high for RST_LEN cycles |

## Verification
A keepalive write can land on the very clock edge on which an expiry is processed. This is the collision that decides whether software wins a race against the timebase. The bench polls the timebase register until its low bits are all ones, and then drives the keepalive write in that same cycle. It does this once with the stage flag at 0 and once with it at 1. It judges the outcome from `irq`, `sys_rst` and the read-back of control register 0 in the following cycle. The expected result in both cases is that the expiry takes precedence.

// File: rtl/twostage_wdt_pkg.sv
package twostage_wdt_pkg;
  // byte offsets of the register map
  localparam int OFS_CTRL0 = 'h0;
  localparam int OFS_CTRL1 = 'h4;
  localparam int OFS_TBASE = 'h8;
  // bit positions inside control register 0
  localparam int BIT_EN_A   = 1;
  localparam int BIT_STAGE  = 2;
  localparam int BIT_RCAUSE = 3;
  // bit position inside control register 1
  localparam int BIT_EN_B   = 0;
endpackage

// File: rtl/wdt2_timebase.sv
module wdt2_timebase #(
  parameter int TB_W       = 32,
  parameter int INTERVAL_N = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TB_W-1:0] tb_val,
  output logic            expiry
);
  logic [TB_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + TB_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // the low INTERVAL_N bits carry out at the coming edge: one pulse per interval
  assign expiry = &cnt_q[INTERVAL_N-1:0];
  assign tb_val = cnt_q;
endmodule

// File: rtl/wdt2_regif.sv
module wdt2_regif
  import twostage_wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int TB_W   = 32
) (
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              stage,
  input  logic              rcause,
  input  logic [TB_W-1:0]   tb_val,
  output logic              wr_ctrl0,
  output logic              wr_ctrl1,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL0 = ADDR_W'(OFS_CTRL0);
  localparam logic [ADDR_W-1:0] A_CTRL1 = ADDR_W'(OFS_CTRL1);
  localparam logic [ADDR_W-1:0] A_TBASE = ADDR_W'(OFS_TBASE);

  logic hit0, hit1, hit_tb;

  always_comb begin
    hit0   = (reg_addr == A_CTRL0);
    hit1   = (reg_addr == A_CTRL1);
    hit_tb = (reg_addr == A_TBASE);
  end

  assign wr_ctrl0 = reg_we & hit0;
  assign wr_ctrl1 = reg_we & hit1;

  always_comb begin
    reg_rdata = '0;
    if (hit0) begin
      reg_rdata[BIT_EN_A]   = en_a;
      reg_rdata[BIT_STAGE]  = stage;
      reg_rdata[BIT_RCAUSE] = rcause;
    end else if (hit1) begin
      reg_rdata[BIT_EN_B] = en_b;
    end else if (hit_tb) begin
      reg_rdata = DATA_W'(tb_val);
    end
  end
endmodule

// File: rtl/wdt2_ctrl.sv
module wdt2_ctrl #(
  parameter bit ENABLE_ONCE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expiry,
  input  logic wr_ctrl0,
  input  logic wr_ctrl1,
  input  logic w_en_a,
  input  logic w_stage_clr,
  input  logic w_rcause_clr,
  input  logic w_en_b,
  output logic en_a,
  output logic en_b,
  output logic stage,
  output logic rcause,
  output logic armed,
  output logic fire,
  output logic irq
);
  logic en_a_q, en_b_q, stage_q, rcause_q, irq_q;
  logic en_a_d, en_b_d, stage_d, rcause_d;
  logic first_exp, upd, lock;

  assign armed     = en_a_q & en_b_q;
  assign first_exp = expiry & armed & ~stage_q;
  assign fire      = expiry & armed & stage_q;

  generate
    if (ENABLE_ONCE) begin : g_once
      logic lock_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= (lock_q | armed) & ~fire;
      end
      assign lock = lock_q | armed;
    end else begin : g_free
      assign lock = 1'b0;
    end
  endgenerate

  // next state: writes first, expiry events override (set beats clear)
  always_comb begin
    en_a_d   = en_a_q;
    en_b_d   = en_b_q;
    stage_d  = stage_q;
    rcause_d = rcause_q;
    if (wr_ctrl0) begin
      en_a_d = w_en_a | (lock & en_a_q);
      if (w_stage_clr)  stage_d  = 1'b0;
      if (w_rcause_clr) rcause_d = 1'b0;
    end
    if (wr_ctrl1) en_b_d = w_en_b | (lock & en_b_q);
    if (first_exp) stage_d = 1'b1;
    if (fire) begin
      stage_d  = 1'b0;
      rcause_d = 1'b1;
      en_a_d   = 1'b0;
      en_b_d   = 1'b0;
    end
  end

  assign upd = wr_ctrl0 | wr_ctrl1 | expiry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a_q   <= 1'b0;
      en_b_q   <= 1'b0;
      stage_q  <= 1'b0;
      rcause_q <= 1'b0;
    end else if (upd) begin
      en_a_q   <= en_a_d;
      en_b_q   <= en_b_d;
      stage_q  <= stage_d;
      rcause_q <= rcause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= first_exp;
  end

  assign en_a   = en_a_q;
  assign en_b   = en_b_q;
  assign stage  = stage_q;
  assign rcause = rcause_q;
  assign irq    = irq_q;
endmodule

// File: rtl/wdt2_rstgen.sv
module wdt2_rstgen #(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic sys_rst
);
  localparam int CW = $clog2(RST_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy, cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = fire | busy;

  always_comb begin
    if (fire) cnt_d = CW'(RST_LEN);
    else      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign sys_rst = busy;
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import twostage_wdt_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int TB_W        = 32,
  parameter int INTERVAL_N  = 16,
  parameter int RST_LEN     = 16,
  parameter bit ENABLE_ONCE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              sys_rst
);
  logic            rst_meta, rst_sync_n;
  logic [TB_W-1:0] tb_val;
  logic            expiry, wr_ctrl0, wr_ctrl1;
  logic            en_a, en_b, stage, rcause, armed, fire;
  logic            wdata_unused;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign wdata_unused = ^reg_wdata;

  wdt2_timebase #(.TB_W(TB_W), .INTERVAL_N(INTERVAL_N)) u_tbase (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tb_val (tb_val),
    .expiry (expiry)
  );

  wdt2_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TB_W(TB_W)) u_regif (
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .en_a      (en_a),
    .en_b      (en_b),
    .stage     (stage),
    .rcause    (rcause),
    .tb_val    (tb_val),
    .wr_ctrl0  (wr_ctrl0),
    .wr_ctrl1  (wr_ctrl1),
    .reg_rdata (reg_rdata)
  );

  wdt2_ctrl #(.ENABLE_ONCE(ENABLE_ONCE)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .expiry       (expiry),
    .wr_ctrl0     (wr_ctrl0),
    .wr_ctrl1     (wr_ctrl1),
    .w_en_a       (reg_wdata[BIT_EN_A]),
    .w_stage_clr  (reg_wdata[BIT_STAGE]),
    .w_rcause_clr (reg_wdata[BIT_RCAUSE]),
    .w_en_b       (reg_wdata[BIT_EN_B]),
    .en_a         (en_a),
    .en_b         (en_b),
    .stage        (stage),
    .rcause       (rcause),
    .armed        (armed),
    .fire         (fire),
    .irq          (irq)
  );

  wdt2_rstgen #(.RST_LEN(RST_LEN)) u_rstgen (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fire    (fire),
    .sys_rst (sys_rst)
  );
endmodule

// File: rtl/twostage_wdt_checker.sv
module twostage_wdt_checker (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic sys_rst,
  input logic en_a,
  input logic en_b,
  input logic stage,
  input logic rcause,
  input logic armed,
  input logic wr_ctrl0,
  input logic w_rcause_clr
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R5

  AST_IRQ_WITH_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stage); // R5

  AST_STAGE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage) |-> $past(armed)); // R4

  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !irq); // R4

  AST_RST_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> rcause); // R7

  AST_RST_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> (!en_a && !en_b && !stage)); // R7

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rcause && !(wr_ctrl0 && w_rcause_clr)) |=> rcause); // R8
endmodule

bind twostage_wdt twostage_wdt_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .irq          (irq),
  .sys_rst      (sys_rst),
  .en_a         (en_a),
  .en_b         (en_b),
  .stage        (stage),
  .rcause       (rcause),
  .armed        (armed),
  .wr_ctrl0     (wr_ctrl0),
  .w_rcause_clr (reg_wdata[3])
);

// File: tb/twostage_wdt_bench.sv
module twostage_wdt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int TBW        = 16;
  localparam int RLEN       = 3;

  typedef struct packed {
    logic        we;
    logic [3:0]  waddr;
    logic [31:0] wdata;
    logic [3:0]  raddr;
    logic [31:0] exp;
  } vec_t;

  // register map vectors (R3): write (optional), then read back
  localparam vec_t VEC [10] = '{
    '{1'b1, 4'h4, 32'h0000_0001, 4'h4, 32'h0000_0001},
    '{1'b1, 4'h4, 32'h0000_0000, 4'h4, 32'h0000_0000},
    '{1'b1, 4'h0, 32'h0000_0002, 4'h0, 32'h0000_0002},
    '{1'b1, 4'h0, 32'h0000_0000, 4'h0, 32'h0000_0000},
    '{1'b1, 4'hC, 32'hFFFF_FFFF, 4'hC, 32'h0000_0000},
    '{1'b0, 4'h0, 32'h0000_0000, 4'h3, 32'h0000_0000},
    '{1'b1, 4'h0, 32'hFFFF_FFF3, 4'h4, 32'h0000_0000},
    '{1'b0, 4'h0, 32'h0000_0000, 4'h0, 32'h0000_0002},
    '{1'b1, 4'h0, 32'h0000_0000, 4'h0, 32'h0000_0000},
    '{1'b1, 4'h4, 32'hFFFF_FFFE, 4'h4, 32'h0000_0000}
  };

  logic        clk, rst_n, reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, rdata_b;
  logic        irq, sys_rst, irq_b, sys_rst_b;
  int          n_chk, n_fail, irq_cnt, rst_cnt;
  logic [31:0] d, db, t0, t1;
  int          k0;

  twostage_wdt #(.ADDR_W(4), .DATA_W(32), .TB_W(TBW), .INTERVAL_N(N),
                 .RST_LEN(RLEN), .ENABLE_ONCE(1'b0)) u_twostage_wdt (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sys_rst(sys_rst));

  twostage_wdt #(.ADDR_W(4), .DATA_W(32), .TB_W(TBW), .INTERVAL_N(N),
                 .RST_LEN(RLEN), .ENABLE_ONCE(1'b1)) u_twostage_wdt_once (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .irq(irq_b), .sys_rst(sys_rst_b));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (irq)     irq_cnt <= irq_cnt + 1;
    if (sys_rst) rst_cnt <= rst_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a);
    reg_addr = a;
    #1;
    d  = reg_rdata;
    db = rdata_b;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // stop in the cycle whose closing edge processes an expiry
  task automatic wait_tick();
    reg_addr = 4'h8;
    forever begin
      @(negedge clk); #1;
      if (reg_rdata[N-1:0] == {N{1'b1}}) break;
    end
  endtask

  task automatic por();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; irq_cnt = 0; rst_cnt = 0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    por();

    // R1 reset state
    rd(4'h0); chk("R1 ctrl0", d, 32'h0);
    rd(4'h4); chk("R1 ctrl1", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 sys_rst", {31'b0, sys_rst}, 32'h0);

    // R3 vector table
    foreach (VEC[i]) begin
      if (VEC[i].we) wr(VEC[i].waddr, VEC[i].wdata);
      rd(VEC[i].raddr);
      chk($sformatf("R3 vec%0d", i), d, VEC[i].exp);
    end

    // R2 timebase advance and write immunity
    rd(4'h8); t0 = d;
    repeat (5) @(negedge clk);
    rd(4'h8); t1 = d;
    chk("R2 advance", t1 - t0, 32'd5);
    wr(4'h8, 32'h0000_1234);
    rd(4'h8);
    chk("R2 write ignored", d, (t1 + 32'd1) & 32'hFFFF);

    // R4 single enable does not arm
    k0 = irq_cnt;
    wr(4'h0, 32'h2);
    wait_tick(); @(negedge clk); @(negedge clk);
    rd(4'h0); chk("R4 en_a only", d, 32'h2);
    wr(4'h0, 32'h0); wr(4'h4, 32'h1);
    wait_tick(); @(negedge clk);
    rd(4'h0); chk("R4 en_b only", d, 32'h0);
    chk("R4 no irq", irq_cnt - k0, 32'd0);

    // R5 first expiry
    wr(4'h0, 32'h2);
    wait_tick(); @(negedge clk);
    chk("R5 irq pulse", {31'b0, irq}, 32'h1);
    rd(4'h0); chk("R5 stage set", d, 32'h6);
    @(negedge clk);
    chk("R5 irq one cycle", {31'b0, irq}, 32'h0);

    // R6 keepalive
    wr(4'h0, 32'h2);
    rd(4'h0); chk("R6 write 0 keeps stage", d, 32'h6);
    wr(4'h0, 32'h6);
    rd(4'h0); chk("R6 keepalive clears", d, 32'h2);
    wait_tick(); @(negedge clk);
    chk("R6 irq again", {31'b0, irq}, 32'h1);
    chk("R6 no reset", {31'b0, sys_rst}, 32'h0);

    // R7 second expiry
    wait_tick(); @(negedge clk);
    chk("R7 sys_rst", {31'b0, sys_rst}, 32'h1);
    chk("R7 no irq", {31'b0, irq}, 32'h0);
    k0 = rst_cnt;
    rd(4'h0); chk("R7 ctrl0", d, 32'h8);
    rd(4'h4); chk("R7 ctrl1", d, 32'h0);
    repeat (RLEN + 1) @(negedge clk);
    chk("R7 pulse length", rst_cnt - k0, RLEN);
    chk("R7 pulse ended", {31'b0, sys_rst}, 32'h0);

    // R8 sticky cause
    rd(4'h0); chk("R8 survives", d, 32'h8);
    wr(4'h0, 32'h4);
    rd(4'h0); chk("R8 write 0 keeps", d, 32'h8);
    wr(4'h0, 32'h8);
    rd(4'h0); chk("R8 write 1 clears", d, 32'h0);

    // R9 collisions: expiry beats keepalive
    wr(4'h4, 32'h1); wr(4'h0, 32'h2);
    wait_tick();
    reg_we = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h6;
    @(negedge clk); reg_we = 1'b0;
    chk("R9 stage0 irq", {31'b0, irq}, 32'h1);
    rd(4'h0); chk("R9 stage0 set", d, 32'h6);
    wait_tick();
    reg_we = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h6;
    @(negedge clk); reg_we = 1'b0;
    chk("R9 stage1 reset", {31'b0, sys_rst}, 32'h1);
    rd(4'h0); chk("R9 stage1 ctrl0", d, 32'h8);
    repeat (RLEN + 1) @(negedge clk);

    // R4 disarm while stage set
    wr(4'h0, 32'h8);
    wr(4'h4, 32'h1); wr(4'h0, 32'h2);
    wait_tick(); @(negedge clk);
    wr(4'h4, 32'h0);
    k0 = rst_cnt;
    wait_tick(); @(negedge clk);
    wait_tick(); @(negedge clk);
    chk("R4 disarmed no reset", rst_cnt - k0, 32'd0);
    rd(4'h0); chk("R4 stage held", d, 32'h6);

    // R10 enable-once lock
    por();
    wr(4'h4, 32'h1); wr(4'h0, 32'h2);
    wr(4'h0, 32'h0); wr(4'h4, 32'h0);
    rd(4'h4);
    chk("R10 free clears", d, 32'h0);
    chk("R10 locked en_b", db, 32'h1);
    rd(4'h0);
    chk("R10 locked en_a", db & 32'h2, 32'h2);
    wait_tick(); @(negedge clk);
    wait_tick(); @(negedge clk);
    chk("R10 locked fires", {31'b0, sys_rst_b}, 32'h1);
    rd(4'h0); chk("R10 fire unlocks ctrl0", db, 32'h8);
    wr(4'h4, 32'h1); wr(4'h4, 32'h0);
    rd(4'h4); chk("R10 unlocked clear", db, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule